// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. A small byte-wide register port gives software a control word, a channel/reference word, a trigger-source field and a 16-bit result split into two bytes. The block derives the converter clock from the system clock with a power-of-two divider. It then runs a fixed 13-tick frame: three ticks of sample-and-hold, then ten trial steps, most significant bit first, each driving a trial code to an external DAC and keeping the bit when the comparator reports that the input is at or above it.

Conversions start from a software write, restart by themselves in free-running mode, or start on the rising edge of one of seven external event lines. At the end of each frame the result is latched, a completion flag is raised, and an interrupt is asserted when enabled. The result can be read right-justified or left-justified. The channel and reference codes are only passed to the analog side.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset every register (addresses 0 to 4) reads 0x00, `irq_o` is low and `dac_code_o` is zero.
- R2: The control word at address 0 holds enable (bit 7), start/busy (bit 6), auto-trigger (bit 5), completion flag (bit 4), interrupt enable (bit 3) and divider select (bits 2:0). Writing bits 7 and 6 both set while idle starts a conversion; bit 6 reads 1 for the whole conversion and 0 after it, and a start write while busy has no effect.
- R3: Divider select 0 and 1 both divide by 2; code k from 2 to 7 divides by 2^k. A conversion lasts exactly 13 converter ticks, i.e. 13 × divisor system clocks.
- R4: `sample_o` is high during the first 3 ticks of a frame with `dac_code_o` zero; the next 10 ticks try bits 9 down to 0, and a bit is kept when `cmp_i` is high at the end of its tick.
- R5: With bit 5 of address 1 clear, address 3 reads result[7:0] and address 4 reads {6'b0, result[9:8]}.
- R6: With bit 5 of address 1 set, address 4 reads result[9:2] and address 3 reads {result[1:0], 6'b0}; the setting applies at read time.
- R7: The completion flag sets in the clock that ends a conversion; `irq_o` equals flag AND interrupt enable.
- R8: The flag clears on a write to address 0 with bit 4 set, or on an `irq_ack_i` pulse; if a completion falls in the same clock as a clear, the flag stays set.
- R9: With auto-trigger set and trigger-source code 0, a new conversion starts in the clock that ends the previous one, with no idle cycle.
- R10: Trigger-source code k (1 to 7, bits 7:5 of address 2) selects `trig_i[k-1]`; with auto-trigger set, its rising edge starts a conversion; edges on other lines or during a conversion are ignored.
- R11: Clearing enable aborts a running conversion: busy drops, the flag is not set and the result bytes keep their old value.
- R12: `ref_sel_o` follows bits 7:6 and `mux_ch_o` follows bits 4:0 of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe for `wr_data_i` |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Completion interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| trig_i | input | 7 | Auto-trigger event lines |
| cmp_i | input | 1 | Comparator: input at or above DAC level |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold phase |
| mux_ch_o | output | 5 | Channel/gain select to the front end |
| ref_sel_o | output | 2 | Reference select to the front end |

## Verification
The completion of a conversion and a flag clear (a write-1 to the flag bit or an acknowledge pulse) can land on the same clock edge. The bench counts the frame length from the start write and places the clear exactly on the completion edge, once per clear path. It judges the outcome by the flag and `irq_o` still being set afterwards, both through a named check and through the per-clock comparison against its behavioural model.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int RES_BITS  = 10;
  localparam int HOLD_TCKS = 3;
  localparam int SEL_BITS  = 3;
  localparam int BUS_BITS  = 16;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MUX  = 3'd1,
    A_TSRC = 3'd2,
    A_RLO  = 3'd3,
    A_RHI  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   div_full;
  logic [SEL_W-1:0] shamt;

  always_comb begin
    shamt    = (sel_i == '0) ? SEL_W'(1) : sel_i;
    div_full = (CNT_W+1)'(1) << shamt;
    lim      = div_full[CNT_W-1:0] - 1'b1;
  end

  assign tick_o = run_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sar_trig_edge.sv
module sar_trig_edge #(
  parameter int SRC_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SRC_W-1:0]       src_i,
  input  logic [(1<<SRC_W)-2:0]  evt_i,
  output logic                   rise_o
);
  localparam int N_EVT = (1 << SRC_W) - 1;

  logic [N_EVT-1:0] hit;
  logic             lvl, prev_q;

  for (genvar g = 1; g <= N_EVT; g++) begin : g_sel
    assign hit[g-1] = (src_i == SRC_W'(g)) & evt_i[g-1];
  end

  assign lvl    = |hit;
  assign rise_o = lvl & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  // R10
  one_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10,
  parameter int SH_T  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             rerun_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] code_o
);
  localparam int FRAME  = SH_T + RES_W;
  localparam int STEP_W = $clog2(FRAME);

  logic              busy_q;
  logic [STEP_W-1:0] step_q, bidx;
  logic [RES_W-1:0]  sar_q, mask, nxt;
  logic              in_sar, last;

  always_comb begin
    in_sar = step_q >= STEP_W'(SH_T);
    bidx   = STEP_W'(FRAME-1) - step_q;
    mask   = in_sar ? (RES_W'(1) << bidx) : '0;
    nxt    = sar_q | (cmp_i ? mask : '0);
    last   = step_q == STEP_W'(FRAME-1);
  end

  assign busy_o   = busy_q;
  assign done_o   = busy_q & ~halt_i & tick_i & last;
  assign sample_o = busy_q & ~in_sar;
  assign dac_o    = busy_q ? (sar_q | mask) : '0;
  assign code_o   = nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      sar_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
      sar_q  <= '0;
    end else if (halt_i) begin
      busy_q <= 1'b0;
      step_q <= '0;
      sar_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (last) begin
        busy_q <= rerun_i;
        step_q <= '0;
        sar_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        sar_q  <= nxt;
      end
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i && !go_i && !halt_i |=> $stable(step_q));
  // R4
  msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && step_q == STEP_W'(SH_T) |-> dac_o == (RES_W'(1) << (RES_W-1)));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int RES_W = RES_BITS,
  parameter int SH_T  = HOLD_TCKS,
  parameter int SEL_W = SEL_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            addr_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_data_i,
  output logic [7:0]            rd_data_o,
  output logic                  irq_o,
  input  logic                  irq_ack_i,
  input  logic [(1<<SEL_W)-2:0] trig_i,
  input  logic                  cmp_i,
  output logic [RES_W-1:0]      dac_code_o,
  output logic                  sample_o,
  output logic [4:0]            mux_ch_o,
  output logic [1:0]            ref_sel_o
);
  localparam int PAD = BUS_BITS - RES_W;

  logic             en_q, auto_q, ie_q, flag_q;
  logic [SEL_W-1:0] ps_q, src_q;
  logic [7:0]       mux_q;
  logic [RES_W-1:0] res_q, code;
  logic             wr_ctrl, go, busy, done, tick, rise, rerun;
  logic [BUS_BITS-1:0] res_bus;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign rerun   = en_q & auto_q & (src_q == '0);
  assign go      = ~busy & ((wr_ctrl & wr_data_i[7] & wr_data_i[6]) |
                            (en_q & auto_q & (src_q != '0) & rise));

  sar_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i, .rst_ni,
    .run_i (busy),
    .clr_i (go | done),
    .sel_i (ps_q),
    .tick_o(tick)
  );

  sar_trig_edge #(.SRC_W(SEL_W)) u_trg (
    .clk_i, .rst_ni,
    .src_i (src_q),
    .evt_i (trig_i),
    .rise_o(rise)
  );

  sar_engine #(.RES_W(RES_W), .SH_T(SH_T)) u_eng (
    .clk_i, .rst_ni,
    .go_i    (go),
    .halt_i  (~en_q),
    .rerun_i (rerun),
    .tick_i  (tick),
    .cmp_i   (cmp_i),
    .busy_o  (busy),
    .done_o  (done),
    .sample_o(sample_o),
    .dac_o   (dac_code_o),
    .code_o  (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; auto_q <= 1'b0; ie_q <= 1'b0; ps_q <= '0;
      mux_q <= '0; src_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL: begin
          en_q   <= wr_data_i[7];
          auto_q <= wr_data_i[5];
          ie_q   <= wr_data_i[3];
          ps_q   <= wr_data_i[SEL_W-1:0];
        end
        A_MUX:   mux_q <= wr_data_i;
        A_TSRC:  src_q <= wr_data_i[7 -: SEL_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  flag_q <= 1'b0;
    else if (done)                                flag_q <= 1'b1;
    else if ((wr_ctrl && wr_data_i[4]) || irq_ack_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (done) res_q <= code;
  end

  assign res_bus = mux_q[5] ? {res_q, {PAD{1'b0}}} : {{PAD{1'b0}}, res_q};

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_data_o = {en_q, busy, auto_q, flag_q, ie_q, ps_q};
      A_MUX:   rd_data_o = mux_q;
      A_TSRC:  rd_data_o = {src_q, {(8-SEL_W){1'b0}}};
      A_RLO:   rd_data_o = res_bus[7:0];
      A_RHI:   rd_data_o = res_bus[15:8];
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o     = flag_q & ie_q;
  assign mux_ch_o  = mux_q[4:0];
  assign ref_sel_o = mux_q[7:6];

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag_q);
  // R8
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done && irq_ack_i |=> !flag_q);
  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !go |=> !busy);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !go |=> !busy);
  // R5
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(res_q));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       irq, ack = 1'b0;
  logic [6:0] trig = '0;
  logic       cmp;
  logic [9:0] dac;
  logic       smp;
  logic [4:0] mch;
  logic [1:0] rsel;
  logic [9:0] vin = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_conv_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq), .irq_ack_i(ack),
    .trig_i(trig), .cmp_i(cmp), .dac_code_o(dac), .sample_o(smp),
    .mux_ch_o(mch), .ref_sel_o(rsel)
  );

  // behavioural reference model
  logic       m_en, m_auto, m_ie, m_flag, m_busy, m_prev;
  logic [2:0] m_ps, m_src;
  logic [7:0] m_mux;
  logic [9:0] m_res;
  int         m_cyc;

  function automatic int divof(input logic [2:0] p);
    return (p == 0) ? 2 : (1 << p);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic [15:0] b;
    b = m_mux[5] ? {m_res, 6'b0} : {6'b0, m_res};
    case (a)
      3'd0: return {m_en, m_busy, m_auto, m_flag, m_ie, m_ps};
      3'd1: return m_mux;
      3'd2: return {m_src, 5'b0};
      3'd3: return b[7:0];
      3'd4: return b[15:8];
      default: return 8'h00;
    endcase
  endfunction

  logic sel_v, rise_v, done_v, go_v, wrc;
  int   dv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_auto = 0; m_ie = 0; m_flag = 0; m_busy = 0; m_prev = 0;
      m_ps = 0; m_src = 0; m_mux = 0; m_res = 0; m_cyc = 0;
    end else begin
      sel_v  = (m_src == 0) ? 1'b0 : trig[m_src-1];
      rise_v = sel_v && !m_prev;
      dv     = divof(m_ps);
      done_v = m_busy && m_en && (m_cyc == 13*dv-1);
      wrc    = wr_en && addr == 3'd0;
      go_v   = !m_busy && ((wrc && wd[7] && wd[6]) ||
                           (m_en && m_auto && m_src != 0 && rise_v));
      if (go_v) begin m_busy = 1; m_cyc = 0; end
      else if (!m_en) begin m_busy = 0; m_cyc = 0; end
      else if (done_v) begin m_busy = m_auto && m_src == 0; m_cyc = 0; end
      else if (m_busy) m_cyc++;
      if (done_v) m_res = vin;
      if (done_v) m_flag = 1;
      else if ((wrc && wd[4]) || ack) m_flag = 0;
      m_prev = sel_v;
      if (wr_en) begin
        case (addr)
          3'd0: begin m_en = wd[7]; m_auto = wd[5]; m_ie = wd[3]; m_ps = wd[2:0]; end
          3'd1: m_mux = wd;
          3'd2: m_src = wd[7:5];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(irq === (m_flag & m_ie), "R7 irq", irq, m_flag & m_ie);
      chk(smp === (m_busy && m_cyc < 3*divof(m_ps)), "R4 sample", smp,
          m_busy && m_cyc < 3*divof(m_ps));
      if (rd !== exp_rd(addr)) begin
        case (addr)
          3'd0: chk(0, "R2 ctrl", rd, exp_rd(addr));
          3'd1: chk(0, "R12 mux", rd, exp_rd(addr));
          3'd2: chk(0, "R10 tsrc", rd, exp_rd(addr));
          3'd3, 3'd4: chk(0, m_mux[5] ? "R6 result" : "R5 result", rd, exp_rd(addr));
          default: chk(0, "R1 unused", rd, 0);
        endcase
      end else checks++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wd = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rdb(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    v = rd;
  endtask

  task automatic measure(output int n);
    n = 0;
    @(negedge clk);
    while (rd[6] === 1'b1 && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 ack = 1'b1;
    @(posedge clk); #1 ack = 1'b0;
  endtask

  initial begin
    int n;
    logic [7:0] v, v2;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rdb(3'(a), v);
      chk(v == 8'h00, "R1 reg reset", v, 0);
    end
    chk(irq == 1'b0 && dac == '0, "R1 irq/dac reset", {irq, dac}, 0);

    // R12 pass-through selects
    wr(3'd1, 8'h95);
    @(negedge clk);
    chk(mch == 5'h15 && rsel == 2'd2, "R12 selects", {rsel, mch}, {2'd2, 5'h15});

    // R2 R3 R5 right-justified, divider 2
    wr(3'd1, 8'hC0);
    vin = 10'h2A5;
    wr(3'd0, 8'hC8);
    measure(n);
    chk(n == 26, "R3 frame div2", n, 26);
    chk(rd[6] == 1'b0, "R2 busy clears", rd[6], 0);
    rdb(3'd3, v); chk(v == 8'hA5, "R5 low byte", v, 8'hA5);
    rdb(3'd4, v); chk(v == 8'h02, "R5 high byte", v, 8'h02);
    chk(irq == 1'b1, "R7 irq on completion", irq, 1);
    wr(3'd0, 8'h98);
    @(negedge clk);
    chk(irq == 1'b0, "R8 write-one clear", irq, 0);

    // R6 left-justified, divider 4, clear by acknowledge
    wr(3'd1, 8'hE0);
    vin = 10'h2C7;
    wr(3'd0, 8'hCA);
    measure(n);
    chk(n == 52, "R3 frame div4", n, 52);
    rdb(3'd4, v); chk(v == 8'hB1, "R6 high byte", v, 8'hB1);
    rdb(3'd3, v); chk(v == 8'hC0, "R6 low byte", v, 8'hC0);
    pulse_ack();
    @(negedge clk);
    chk(irq == 1'b0, "R8 ack clear", irq, 0);

    // R3 select 1 also divides by 2; select 7 by 128
    vin = 10'h000;
    wr(3'd0, 8'hD9);
    measure(n);
    chk(n == 26, "R3 frame sel1", n, 26);
    rdb(3'd4, v); chk(v == 8'h00, "R6 zero result", v, 0);
    vin = 10'h3FF;
    wr(3'd0, 8'hDF);
    addr = 3'd0;
    measure(n);
    chk(n == 1664, "R3 frame div128", n, 1664);
    rdb(3'd4, v); chk(v == 8'hFF, "R6 full scale", v, 8'hFF);
    wr(3'd1, 8'h00);

    // R8 completion and write-one clear on the same edge
    vin = 10'h155;
    wr(3'd0, 8'hD8);
    repeat (24) @(posedge clk);
    wr(3'd0, 8'h98);
    @(negedge clk);
    chk(irq == 1'b1, "R8 set wins over write", irq, 1);

    // R8 completion and acknowledge on the same edge
    wr(3'd0, 8'hD8);
    repeat (24) @(posedge clk);
    pulse_ack();
    @(negedge clk);
    chk(irq == 1'b1, "R8 set wins over ack", irq, 1);

    // R9 free-running
    wr(3'd2, 8'h00);
    vin = 10'h0F0;
    wr(3'd0, 8'hF8);
    repeat (28) @(negedge clk);
    chk(irq == 1'b1 && rd[6] == 1'b1, "R9 restart after completion", {irq, rd[6]}, 2'b11);
    wr(3'd0, 8'hB8);
    @(negedge clk);
    chk(irq == 1'b0, "R9 flag cleared mid-run", irq, 0);
    repeat (30) @(negedge clk);
    chk(irq == 1'b1, "R9 second completion", irq, 1);
    rdb(3'd3, v); chk(v == 8'hF0, "R9 result", v, 8'hF0);
    wr(3'd0, 8'h98);
    measure(n);
    repeat (3) @(negedge clk);
    chk(rd[6] == 1'b0, "R9 stops without auto", rd[6], 0);

    // R10 event trigger on line 2 (code 3)
    wr(3'd2, 8'h60);
    wr(3'd0, 8'hB8);
    @(posedge clk); #1 trig[0] = 1'b1;
    repeat (3) @(posedge clk); #1 trig[0] = 1'b0;
    @(negedge clk);
    chk(rd[6] == 1'b0, "R10 other line ignored", rd[6], 0);
    vin = 10'h321;
    fork
      begin
        @(posedge clk); #1 trig[2] = 1'b1;
        repeat (10) @(posedge clk); #1 trig[2] = 1'b0;
        @(posedge clk); #1 trig[2] = 1'b1;
        repeat (3) @(posedge clk); #1 trig[2] = 1'b0;
      end
      begin
        @(posedge clk); @(posedge clk); #2;
        measure(n);
      end
    join
    chk(n == 26, "R10 edge while busy ignored", n, 26);
    repeat (5) @(negedge clk);
    chk(rd[6] == 1'b0, "R10 no second conversion", rd[6], 0);
    rdb(3'd3, v); chk(v == 8'h21, "R10 triggered result", v, 8'h21);

    // R11 abort by clearing enable
    vin = 10'h0AA;
    wr(3'd0, 8'hD8);
    repeat (5) @(posedge clk);
    wr(3'd0, 8'h08);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, "R11 no flag after abort", irq, 0);
    rdb(3'd0, v); chk(v[6] == 1'b0, "R11 busy dropped", v[6], 0);
    rdb(3'd3, v2); chk(v2 == 8'h21, "R11 result kept", v2, 8'h21);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule